// File: doc/BRIEF.md
# Conversion Sample Queue with Threshold Request

This block holds converter results until software or a DMA engine collects them. Each conversion-done pulse brings a 12-bit value and an error flag. When queueing is switched on, the block formats the sample into a 16-bit word and appends it to an eight-entry first-in first-out store. A pop strobe removes the oldest word. The word at the head is always visible on the read port, and the port shows zero when the store is empty.

The fill level goes out together with full and empty indications. The level is compared against a programmable 4-bit threshold. That comparison drives a raw interrupt and, when a DMA enable is set, a DMA request. Two sticky flags record a push into a full store and a pop from an empty store, and each one clears only on its own clear strobe. The interrupt output combines the raw condition with an enable input and a force input.

Top module: `smpf_top`

## Requirements
- R1: After a synchronous active-low reset, level is 0, empty is 1, full is 0, both sticky flags are 0 and rd_word is 0.
- R2: A sample is queued only when conv_done and fifo_en are both 1 on a clock edge. With fifo_en at 0 a conversion leaves level and contents unchanged.
- R3: A queued word holds the 12-bit value in bits 11:0. Bit 15 equals the sample's error flag when err_cap is 1 and is 0 otherwise. All other bits are 0. Words leave the queue in arrival order.
- R4: When byte_mode is 1 at push time, bits 7:0 hold the value shifted right by 4 and bits 14:8 are 0. The error flag still appears at bit 15 under the same rule as in R3.
- R5: level counts the stored words, from 0 to 8. full is 1 exactly at 8 and empty is 1 exactly at 0. A push and a pop in the same cycle leave level unchanged whenever the pop finds data.
- R6: irq_raw is 1 when level >= thresh. dreq is irq_raw AND dreq_en. Both follow level in the same cycle.
- R7: A push while full, with no pop in that cycle, sets over_flag from the next cycle on. The new sample is discarded and the stored contents stay unchanged.
- R8: A pop while empty sets under_flag from the next cycle on. rd_word reads 0 and no pointer moves. A push in that same cycle is still stored.
- R9: over_flag and under_flag stay set until a 1 on clr_over or clr_under, respectively. When a new event arrives in the same cycle as the clear, the flag stays set.
- R10: irq_out equals (irq_raw AND irq_en) OR irq_force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle pulse: a conversion has completed |
| conv_val | input | 12 | Conversion value |
| conv_err | input | 1 | Conversion error flag |
| fifo_en | input | 1 | Queue completed conversions |
| err_cap | input | 1 | Place the error flag in bit 15 of queued words |
| byte_mode | input | 1 | Store the value shifted right by 4 |
| thresh | input | 4 | Level threshold for request and raw interrupt |
| dreq_en | input | 1 | Allow the DMA request |
| pop | input | 1 | Remove the head word at this clock edge |
| clr_over | input | 1 | Clear the overflow flag |
| clr_under | input | 1 | Clear the underflow flag |
| irq_en | input | 1 | Interrupt enable |
| irq_force | input | 1 | Interrupt force |
| rd_word | output | 16 | Head word, 0 when empty |
| level | output | 4 | Number of stored words |
| full | output | 1 | Store holds 8 words |
| empty | output | 1 | Store holds no words |
| over_flag | output | 1 | Sticky overflow |
| under_flag | output | 1 | Sticky underflow |
| dreq | output | 1 | DMA request |
| irq_raw | output | 1 | Raw threshold interrupt |
| irq_out | output | 1 | Interrupt after enable and force |

## Verification
A corrupted pointer or count shows up on the next cycle. Either rd_word returns a word other than the oldest one the model still holds, or level, full, empty, dreq and irq_raw disagree with the model's queue length. The bench compares all of these after every clock edge, so an error is caught within one cycle of its cause. A flag that fails to set or drops too early is caught on the cycle after the event or the clear. This matters most in the cycles that combine a push, a pop and a clear against a full or an empty store.

// File: rtl/smpf_pkg.sv
// Shared widths and the raw sample type for the conversion sample queue.
// Assumes a 12-bit converter value and a 16-bit read word.
package smpf_pkg;
    parameter int VAL_W   = 12;
    parameter int WORD_W  = 16;
    parameter int BYTE_W  = 8;
    parameter int ERR_BIT = 15;

    typedef struct packed {
        logic             err;
        logic [VAL_W-1:0] val;
    } sample_t;
endpackage

// File: rtl/smpf_format.sv
// Turns a raw sample into the stored word. Assumes ERR_BIT lies above the
// value field, so the optional byte shift never moves the error bit.
module smpf_format
    import smpf_pkg::*;
(
    input  sample_t             smp,
    input  logic                err_cap,
    input  logic                byte_mode,
    output logic [WORD_W-1:0]   word
);
    // Place the value (full width or top byte) and the optional error bit.
    always_comb begin
        word = '0;
        if (byte_mode)
            word[BYTE_W-1:0] = smp.val[VAL_W-1 -: BYTE_W];
        else
            word[VAL_W-1:0] = smp.val;
        word[ERR_BIT] = err_cap & smp.err;
    end
endmodule

// File: rtl/smpf_store.sv
// Circular word store with a separate level counter. Assumes DEPTH is a
// power of two so the pointers wrap by overflow. A push into a full store
// is dropped unless a pop frees a slot in the same cycle. A pop from an
// empty store moves nothing.
module smpf_store #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 16,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [WORD_W-1:0]  wr_word,
    input  logic               rd_req,
    output logic [WORD_W-1:0]  rd_word,
    output logic [LVL_W-1:0]   level,
    output logic               full,
    output logic               empty,
    output logic               ovf_evt,
    output logic               udf_evt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [DEPTH-1:0]  we;
    logic              wr_ok, rd_ok;

    // Status derived from the level counter.
    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign wr_ok   = wr_req & (~full | rd_req);
    assign rd_ok   = rd_req & ~empty;
    assign ovf_evt = wr_req & full & ~rd_req;
    assign udf_evt = rd_req & empty;
    assign rd_word = empty ? '0 : mem[rd_ptr];

    // Per-entry write enable decoded from the write pointer.
    for (genvar g = 0; g < DEPTH; g++) begin : g_we
        assign we[g] = wr_ok && (wr_ptr == PTR_W'(g));
    end

    // Entry storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (we[i]) mem[i] <= wr_word;
        end
    end

    // Pointer advance on accepted push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + PTR_W'(1);
            if (rd_ok) rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    // Level counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/smpf_flags.sv
// Sticky error flags and threshold request logic. Assumes the event inputs
// are single-cycle qualifiers; a set in the same cycle as a clear wins.
module smpf_flags #(
    parameter int LVL_W = 4,
    parameter int TH_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  level,
    input  logic [TH_W-1:0]   thresh,
    input  logic              dreq_en,
    input  logic              ovf_evt,
    input  logic              udf_evt,
    input  logic              clr_over,
    input  logic              clr_under,
    input  logic              irq_en,
    input  logic              irq_force,
    output logic              over_flag,
    output logic              under_flag,
    output logic              dreq,
    output logic              irq_raw,
    output logic              irq_out
);
    localparam int CMP_W = (LVL_W > TH_W) ? LVL_W : TH_W;
    localparam int NFLAG = 2;

    logic [NFLAG-1:0] set_v, clr_v, flg;

    assign set_v = {udf_evt, ovf_evt};
    assign clr_v = {clr_under, clr_over};

    // One sticky bit per error kind.
    for (genvar g = 0; g < NFLAG; g++) begin : g_sticky
        logic q;
        // Hold until cleared; a new event overrides the clear.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= 1'b0;
            else        q <= (q & ~clr_v[g]) | set_v[g];
        end
        assign flg[g] = q;
    end

    assign over_flag  = flg[0];
    assign under_flag = flg[1];

    // Threshold comparison and interrupt combination.
    always_comb begin
        irq_raw = CMP_W'(level) >= CMP_W'(thresh);
        dreq    = irq_raw & dreq_en;
        irq_out = (irq_raw & irq_en) | irq_force;
    end
endmodule

// File: rtl/smpf_top.sv
// Conversion sample queue top. Formats each accepted conversion, stores it,
// and raises request and interrupt outputs from the fill level.
// Assumes conv_done is a one-cycle pulse and that DEPTH is a power of two.
module smpf_top
    import smpf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TH_W  = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               conv_done,
    input  logic [VAL_W-1:0]   conv_val,
    input  logic               conv_err,
    input  logic               fifo_en,
    input  logic               err_cap,
    input  logic               byte_mode,
    input  logic [TH_W-1:0]    thresh,
    input  logic               dreq_en,
    input  logic               pop,
    input  logic               clr_over,
    input  logic               clr_under,
    input  logic               irq_en,
    input  logic               irq_force,
    output logic [WORD_W-1:0]  rd_word,
    output logic [LVL_W-1:0]   level,
    output logic               full,
    output logic               empty,
    output logic               over_flag,
    output logic               under_flag,
    output logic               dreq,
    output logic               irq_raw,
    output logic               irq_out
);
    sample_t           smp;
    logic [WORD_W-1:0] fmt_word;
    logic              push_req, ovf_evt, udf_evt;

    // Qualify the conversion pulse with the queue enable.
    assign push_req = conv_done & fifo_en;
    assign smp      = '{err: conv_err, val: conv_val};

    smpf_format u_fmt (
        .smp       (smp),
        .err_cap   (err_cap),
        .byte_mode (byte_mode),
        .word      (fmt_word)
    );

    smpf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .LVL_W(LVL_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (push_req),
        .wr_word (fmt_word),
        .rd_req  (pop),
        .rd_word (rd_word),
        .level   (level),
        .full    (full),
        .empty   (empty),
        .ovf_evt (ovf_evt),
        .udf_evt (udf_evt)
    );

    smpf_flags #(.LVL_W(LVL_W), .TH_W(TH_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (level),
        .thresh     (thresh),
        .dreq_en    (dreq_en),
        .ovf_evt    (ovf_evt),
        .udf_evt    (udf_evt),
        .clr_over   (clr_over),
        .clr_under  (clr_under),
        .irq_en     (irq_en),
        .irq_force  (irq_force),
        .over_flag  (over_flag),
        .under_flag (under_flag),
        .dreq       (dreq),
        .irq_raw    (irq_raw),
        .irq_out    (irq_out)
    );
endmodule

// File: rtl/smpf_chk.sv
// Port-level properties of the sample queue, bound to every smpf_top.
module smpf_chk
    import smpf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TH_W  = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               conv_done,
    input logic [VAL_W-1:0]   conv_val,
    input logic               conv_err,
    input logic               fifo_en,
    input logic               err_cap,
    input logic               byte_mode,
    input logic [TH_W-1:0]    thresh,
    input logic               dreq_en,
    input logic               pop,
    input logic               clr_over,
    input logic               clr_under,
    input logic               irq_en,
    input logic               irq_force,
    input logic [WORD_W-1:0]  rd_word,
    input logic [LVL_W-1:0]   level,
    input logic               full,
    input logic               empty,
    input logic               over_flag,
    input logic               under_flag,
    input logic               dreq,
    input logic               irq_raw,
    input logic               irq_out
);
    // R2
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(conv_done && fifo_en) && !pop) |=> $stable(level));
    // R5
    full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    // R5
    level_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    // R6
    dreq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dreq_en |-> !dreq);
    // R6
    thresh_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '0) |-> irq_raw);
    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && fifo_en && full && !pop) |=> (full && over_flag && $stable(rd_word)));
    // R8
    udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> under_flag);
    // R8
    udf_still_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !(conv_done && fifo_en)) |=> (empty && rd_word == '0));
    // R9
    over_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (over_flag && !clr_over) |=> over_flag);
    // R9
    under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (under_flag && !clr_under) |=> under_flag);
    // R10
    force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_force |-> irq_out);
    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_force && !irq_en) |-> !irq_out);
endmodule

bind smpf_top smpf_chk #(.DEPTH(DEPTH), .TH_W(TH_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_smpf_top.sv
module sim_smpf_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        conv_done, conv_err, fifo_en, err_cap, byte_mode;
    logic [11:0] conv_val;
    logic [3:0]  thresh;
    logic        dreq_en, pop, clr_over, clr_under, irq_en, irq_force;
    logic [15:0] rd_word;
    logic [3:0]  level;
    logic        full, empty, over_flag, under_flag, dreq, irq_raw, irq_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    logic [15:0] q[$];
    bit          m_over, m_under;

    always #2 clk = ~clk;

    smpf_top u0 (.*);

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // advance the model by one clock edge using the current inputs
    task automatic model_update();
        bit set_o, set_u;
        logic [15:0] w;
        set_o = 0; set_u = 0;
        if (pop) begin
            if (q.size() == 0) set_u = 1;
            else void'(q.pop_front());
        end
        if (conv_done && fifo_en) begin
            w = 16'h0;
            if (byte_mode) w[7:0] = conv_val >> 4;
            else           w[11:0] = conv_val;
            w[15] = err_cap & conv_err;
            if (q.size() < 8) q.push_back(w);
            else              set_o = 1;
        end
        m_over  = (m_over  & ~clr_over)  | set_o;
        m_under = (m_under & ~clr_under) | set_u;
    endtask

    task automatic compare_all();
        int n;
        bit raw;
        n   = q.size();
        raw = (n >= int'(thresh));
        check("R5 level", int'(level), n);
        check("R5 full", int'(full), int'(n == 8));
        check("R5 empty", int'(empty), int'(n == 0));
        check("R3 rd_word", int'(rd_word), (n == 0) ? 0 : int'(q[0]));
        check("R7 over_flag", int'(over_flag), int'(m_over));
        check("R8 under_flag", int'(under_flag), int'(m_under));
        check("R6 irq_raw", int'(irq_raw), int'(raw));
        check("R6 dreq", int'(dreq), int'(raw & dreq_en));
        check("R10 irq_out", int'(irq_out), int'((raw & irq_en) | irq_force));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic push(input logic [11:0] v, input logic e);
        conv_val = v; conv_err = e; conv_done = 1;
        cyc();
        conv_done = 0;
    endtask

    task automatic pop_one();
        pop = 1;
        cyc();
        pop = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog act=hung exp=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr;
        rst_n = 0; conv_done = 0; conv_val = 0; conv_err = 0;
        fifo_en = 0; err_cap = 0; byte_mode = 0; thresh = 4'd5;
        dreq_en = 0; pop = 0; clr_over = 0; clr_under = 0;
        irq_en = 0; irq_force = 0;
        m_over = 0; m_under = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 level", int'(level), 0);
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 flags", int'({over_flag, under_flag}), 0);
        check("R1 rd_word", int'(rd_word), 0);

        // R2 queueing disabled
        push(12'h3C3, 1'b1);
        check("R2 no push", int'(level), 0);

        // R3 format without error capture, then with it
        fifo_en = 1;
        push(12'hABC, 1'b1);
        check("R3 word no err", int'(rd_word), 'h0ABC);
        pop_one();
        err_cap = 1;
        push(12'h5A5, 1'b0);
        check("R3 err clear", int'(rd_word), 'h05A5);
        pop_one();
        // R4 byte mode keeps error at bit 15
        byte_mode = 1;
        push(12'hABC, 1'b1);
        check("R4 byte word", int'(rd_word), 'h80AB);
        pop_one();
        byte_mode = 0;

        // fill to full with request enabled (R5, R6)
        dreq_en = 1; irq_en = 1;
        for (int i = 0; i < 8; i++) push(12'(i * 'h111 + 1), i[0]);
        check("R5 full at 8", int'(full), 1);
        check("R6 dreq at 8", int'(dreq), 1);
        // R7 overflow discards sample
        push(12'hFFF, 1'b1);
        check("R7 over set", int'(over_flag), 1);
        check("R7 head kept", int'(rd_word), 'h0001);
        check("R7 level kept", int'(level), 8);
        // R9 clear with a simultaneous event keeps flag
        clr_over = 1;
        push(12'hEEE, 1'b0);
        check("R9 set wins", int'(over_flag), 1);
        cyc();
        clr_over = 0;
        check("R9 cleared", int'(over_flag), 0);
        // R5 push and pop while full
        pop = 1; conv_val = 12'h777; conv_err = 0; conv_done = 1;
        cyc();
        pop = 0; conv_done = 0;
        check("R5 level steady", int'(level), 8);
        check("R7 no over", int'(over_flag), 0);
        // drain
        for (int i = 0; i < 8; i++) pop_one();
        // R8 underflow
        pop_one();
        check("R8 under set", int'(under_flag), 1);
        check("R8 rd zero", int'(rd_word), 0);
        check("R8 level zero", int'(level), 0);
        // R8 pop on empty with push: sample stored
        pop = 1; conv_val = 12'h456; conv_err = 1; conv_done = 1;
        cyc();
        pop = 0; conv_done = 0;
        check("R8 push kept", int'(rd_word), 'h8456);
        clr_under = 1; cyc(); clr_under = 0;
        check("R9 under cleared", int'(under_flag), 0);
        // R10 force with enable off
        irq_en = 0; irq_force = 1; thresh = 4'd9;
        cyc();
        check("R10 forced", int'(irq_out), 1);
        irq_force = 0;
        cyc();
        check("R10 off", int'(irq_out), 0);

        // mixed traffic, compared every cycle
        lfsr = 32'h1ACE;
        for (int i = 0; i < 2000; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
            conv_done = lfsr[0] | lfsr[1];
            pop       = lfsr[2] & (lfsr[3] | (i % 200 > 100));
            fifo_en   = lfsr[4] | lfsr[5] | lfsr[6];
            err_cap   = lfsr[7];
            byte_mode = lfsr[8] & lfsr[9];
            conv_err  = lfsr[10];
            conv_val  = lfsr[22:11];
            if (i % 16 == 0) thresh = lfsr[26:23];
            dreq_en   = lfsr[27] | lfsr[28];
            irq_en    = lfsr[29];
            irq_force = lfsr[30] & lfsr[31] & lfsr[1];
            clr_over  = (lfsr[12:9] == 4'h3);
            clr_under = (lfsr[16:13] == 4'h5);
            cyc();
        end
        conv_done = 0; pop = 0; clr_over = 0; clr_under = 0;
        cyc();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule